// File: doc/BRIEF.md
# Deadline Tick Timer

This block keeps a free-running 63-bit tick count next to a programmable 63-bit deadline. The count goes up by one on every prescaled tick. It has no limit and no reload. When software has armed a deadline and the count reaches or passes it, the block emits a single-cycle match pulse. That pulse sets the timer's bit in a soft-interrupt set vector.

A single enable state is shared by the count and the deadline. The top bit of any 64-bit write to either register sets this state: a 1 means disabled and a 0 means enabled. A read of the count returns that flag in bit 63.

The timer is one-shot. After it fires it stays idle until software writes a new deadline. A deadline of zero, or a deadline written with the top bit set, disarms the timer. A deadline that lies at or behind the current count fires on the next tick. A build parameter selects which interrupt bit the pulse drives: bit 0 for the processor tick timer or bit 16 for the system tick timer. A second parameter sets the tick prescaler ratio.

Top module: `deadline_tick_timer`

## Requirements
- R1: While reset is high and after it is released, the count read value is 64'h8000_0000_0000_0000 (count 0, disabled), the compare read value is 64'h8000_0000_0000_0000, match is 0 and no deadline is armed.
- R2: The 63-bit count increments by exactly one on each prescaled tick and holds its value otherwise. It wraps modulo 2^63.
- R3: A count write loads bits 62:0 into the count and bit 63 into the shared disable flag. Bit 63 of the count read value always equals that flag.
- R4: A compare write with bit 63 set disables the timer and disarms any pending deadline, so no match follows even when the count passes the old deadline.
- R5: A compare write with bit 63 clear and bits 62:0 equal to zero clears the disable flag but leaves the timer disarmed, so no match follows.
- R6: A compare write with bit 63 clear and a nonzero deadline arms the timer. The match pulse is high for one cycle, in the same cycle in which the count read value first equals the deadline.
- R7: A deadline armed at or below the current count fires on the first tick after the write.
- R8: After a match the timer is idle. Further ticks produce no match until a new compare write.
- R9: irq_set carries match on bit 0 when the kind parameter is TK_TICK and on bit 16 when it is TK_SYSTEM. All other bits are 0.
- R10: With prescale ratio N, the count advances once per N cycles in which tick_en is high.
- R11: The count keeps advancing while the disable flag is set.
- R12: While the disable flag is set, an armed deadline produces no match, even when the count passes it.
- R13: The compare read value returns the last 64-bit value written to the compare register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Clock-enable input to the prescaler |
| cnt_we | input | 1 | Write strobe for the count register |
| cmp_we | input | 1 | Write strobe for the compare register |
| wr_data | input | 64 | Write value: bit 63 is the disable flag, bits 62:0 the count or deadline |
| count_rd | output | 64 | Disable flag in bit 63, current count in bits 62:0 |
| cmp_rd | output | 64 | Last written compare value |
| match | output | 1 | One-cycle pulse when the armed deadline is reached |
| irq_set | output | 32 | Soft-interrupt set vector carrying match on the selected bit |

## Verification
A wrong armed state is visible at the match port on the next tick. A lost disarm gives a pulse that should not happen, and a failure to arm gives a missing pulse. A stuck arm gives a second pulse on the tick after a match. A wrong comparator or count register shows as a pulse one tick early or late against the count read in the same cycle. A stale disable flag shows at once in bit 63 of the count read. A prescaler phase error shifts the count after a few tick enables.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [0:0] {TK_TICK = 1'b0, TK_SYSTEM = 1'b1} timer_kind_e;

  function automatic int irq_bit_of(timer_kind_e k);
    return (k == TK_SYSTEM) ? 16 : 0;
  endfunction
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  output logic step
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_direct
      assign step = tick_en;
    end else begin : g_div
      logic [PW-1:0] ph_q;
      assign step = tick_en && (ph_q == PW'(DIV - 1));
      always_ff @(posedge clk) begin
        if (rst)          ph_q <= '0;
        else if (step)    ph_q <= '0;
        else if (tick_en) ph_q <= ph_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int CNT_W = 63,
  localparam int DW = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             cnt_we,
  input  logic             cmp_we,
  input  logic [DW-1:0]    wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next,
  output logic             dis_q
);
  assign cnt_next = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dis_q <= 1'b1;
    end else begin
      if (cnt_we)      cnt_q <= wr_data[CNT_W-1:0];
      else if (step)   cnt_q <= cnt_next;
      if (cnt_we || cmp_we) dis_q <= wr_data[DW-1];
    end
  end

  AST_RESET_COUNT: assert property (@(posedge clk) rst |=> (cnt_q == '0 && dis_q)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && !cnt_we) |=> cnt_q == $past(cnt_q) + 1'b1); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step && !cnt_we) |=> $stable(cnt_q)); // R2
  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> (cnt_q == $past(wr_data[CNT_W-1:0]) && dis_q == $past(wr_data[DW-1]))); // R3
endmodule

// File: rtl/tt_deadline.sv
module tt_deadline #(
  parameter int CNT_W = 63,
  localparam int DW = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             dis,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic             cmp_we,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    cmp_q,
  output logic             match
);
  logic armed_q;
  logic fire;
  logic arm_req;

  assign arm_req = !wr_data[DW-1] && (wr_data[CNT_W-1:0] != '0);
  assign fire    = armed_q && !dis && step && (cnt_next >= cmp_q[CNT_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q   <= {1'b1, {CNT_W{1'b0}}};
      armed_q <= 1'b0;
      match   <= 1'b0;
    end else begin
      match <= fire;
      if (cmp_we) begin
        cmp_q   <= wr_data;
        armed_q <= arm_req;
      end else if (fire) begin
        armed_q <= 1'b0;
      end
    end
  end

  AST_DISABLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cmp_we && wr_data[DW-1]) |=> ##1 !match); // R4
  AST_ZERO_DEADLINE: assert property (@(posedge clk) disable iff (rst)
    (cmp_we && !wr_data[DW-1] && wr_data[CNT_W-1:0] == '0) |=> ##1 !match); // R5
  AST_MATCH_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    match |-> $past(step)); // R6
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (match && !$past(cmp_we)) |=> !match); // R8
endmodule

// File: rtl/deadline_tick_timer.sv
module deadline_tick_timer #(
  parameter int                  CNT_W = 63,
  parameter int                  DIV   = 1,
  parameter int                  IRQ_W = 32,
  parameter tt_pkg::timer_kind_e KIND  = tt_pkg::TK_TICK,
  localparam int DW      = CNT_W + 1,
  localparam int IRQ_BIT = tt_pkg::irq_bit_of(KIND)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             cnt_we,
  input  logic             cmp_we,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    count_rd,
  output logic [DW-1:0]    cmp_rd,
  output logic             match,
  output logic [IRQ_W-1:0] irq_set
);
  logic             step;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;
  logic             dis_q;

  tt_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .tick_en(tick_en), .step(step)
  );

  tt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .cnt_we(cnt_we), .cmp_we(cmp_we),
    .wr_data(wr_data), .cnt_q(cnt_q), .cnt_next(cnt_next), .dis_q(dis_q)
  );

  tt_deadline #(.CNT_W(CNT_W)) u_dl (
    .clk(clk), .rst(rst), .step(step), .dis(dis_q), .cnt_next(cnt_next),
    .cmp_we(cmp_we), .wr_data(wr_data), .cmp_q(cmp_rd), .match(match)
  );

  assign count_rd = {dis_q, cnt_q};

  generate
    for (genvar i = 0; i < IRQ_W; i++) begin : g_irq
      if (i == IRQ_BIT) begin : g_hit
        assign irq_set[i] = match;
      end else begin : g_zero
        assign irq_set[i] = 1'b0;
      end
    end
  endgenerate

  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_set) && (irq_set[IRQ_BIT] == match)); // R9
endmodule

// File: tb/sim_deadline_tick_timer.sv
module sim_deadline_tick_timer;
  import tt_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic        tick0 = 1'b0, tick1 = 1'b0;
  logic        cnt_we0 = 1'b0, cmp_we0 = 1'b0, cnt_we1 = 1'b0, cmp_we1 = 1'b0;
  logic [63:0] wd = '0;
  logic [63:0] count0, cmp0, count1, cmp1;
  logic        match0, match1;
  logic [31:0] irq0, irq1;

  deadline_tick_timer u0 (
    .clk(clk), .rst(rst), .tick_en(tick0), .cnt_we(cnt_we0), .cmp_we(cmp_we0),
    .wr_data(wd), .count_rd(count0), .cmp_rd(cmp0), .match(match0), .irq_set(irq0)
  );

  deadline_tick_timer #(.DIV(4), .KIND(TK_SYSTEM)) u1 (
    .clk(clk), .rst(rst), .tick_en(tick1), .cnt_we(cnt_we1), .cmp_we(cmp_we1),
    .wr_data(wd), .count_rd(count1), .cmp_rd(cmp1), .match(match1), .irq_set(irq1)
  );

  int checks = 0, failures = 0;
  int m0 = 0, m1 = 0, irq_bad = 0;
  logic [63:0] at_match = '0;
  bit done = 0;

  typedef struct packed {
    logic [1:0]  op;   // 0 count write, 1 compare write, 2 ticks
    logic [63:0] data;
    logic [7:0]  n;
    logic [63:0] exp_cnt;
    logic [1:0]  exp_m;
  } vec_t;

  localparam vec_t TBL [16] = '{
    '{2'd2, 64'h0, 8'd3,  64'h8000_0000_0000_0003, 2'd0},  // R11
    '{2'd0, 64'h10, 8'd0, 64'h0000_0000_0000_0010, 2'd0},  // R3
    '{2'd1, 64'h14, 8'd0, 64'h10, 2'd0},
    '{2'd2, 64'h0, 8'd3,  64'h13, 2'd0},
    '{2'd2, 64'h0, 8'd1,  64'h14, 2'd1},                   // R6
    '{2'd2, 64'h0, 8'd10, 64'h1E, 2'd0},                   // R8
    '{2'd1, 64'h5, 8'd0,  64'h1E, 2'd0},
    '{2'd2, 64'h0, 8'd1,  64'h1F, 2'd1},                   // R7
    '{2'd1, 64'h8000_0000_0000_0030, 8'd0, 64'h8000_0000_0000_001F, 2'd0},
    '{2'd2, 64'h0, 8'd20, 64'h8000_0000_0000_0033, 2'd0},  // R4
    '{2'd1, 64'h0, 8'd0,  64'h33, 2'd0},
    '{2'd2, 64'h0, 8'd5,  64'h38, 2'd0},                   // R5
    '{2'd1, 64'h3A, 8'd0, 64'h38, 2'd0},
    '{2'd0, 64'h8000_0000_0000_0038, 8'd0, 64'h8000_0000_0000_0038, 2'd0},
    '{2'd2, 64'h0, 8'd4,  64'h8000_0000_0000_003C, 2'd0},  // R12
    '{2'd1, 64'h3D, 8'd0, 64'h3C, 2'd0}
  };

  task automatic sample();
    if (match0) begin m0++; at_match = count0; end
    if (match1) m1++;
    if (irq0 != {31'b0, match0} || irq1 != ({31'b0, match1} << 16)) irq_bad++;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    sample();
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 count during reset", count0, 64'h8000_0000_0000_0000);
    rst = 1'b0;
    cyc();
    chk("R1 count after reset", count0, 64'h8000_0000_0000_0000);
    chk("R1 compare after reset", cmp0, 64'h8000_0000_0000_0000);
    chk("R1 match after reset", {63'b0, match0}, 64'h0);

    foreach (TBL[i]) begin
      m0 = 0;
      wd = TBL[i].data;
      case (TBL[i].op)
        2'd0: begin cnt_we0 = 1'b1; cyc(); cnt_we0 = 1'b0; end
        2'd1: begin cmp_we0 = 1'b1; cyc(); cmp_we0 = 1'b0; end
        default: begin
          tick0 = 1'b1;
          for (int k = 0; k < TBL[i].n; k++) cyc();
          tick0 = 1'b0;
        end
      endcase
      chk($sformatf("R2/R3 table row %0d count", i), count0, TBL[i].exp_cnt);
      chk($sformatf("R4-R8 table row %0d matches", i), 64'(m0), 64'(TBL[i].exp_m));
    end

    // R6 re-armed deadline: pulse in the cycle the count shows the deadline
    m0 = 0;
    tick0 = 1'b1; cyc(); tick0 = 1'b0;
    chk("R6 match count", 64'(m0), 64'd1);
    chk("R6 count at match", at_match, 64'h3D);
    chk("R13 compare readback", cmp0, 64'h3D);
    cyc();
    chk("R8 match low after pulse", {63'b0, match0}, 64'h0);

    // R10 prescaler on u1 (divide by 4), R9 system bit 16
    wd = 64'h0; cnt_we1 = 1'b1; cyc(); cnt_we1 = 1'b0;
    tick1 = 1'b1;
    for (int k = 0; k < 8; k++) cyc();
    tick1 = 1'b0;
    chk("R10 prescaled count", count1, 64'd2);
    wd = 64'h5; cmp_we1 = 1'b1; cyc(); cmp_we1 = 1'b0;
    m1 = 0;
    tick1 = 1'b1;
    for (int k = 0; k < 11; k++) cyc();
    chk("R10 no early match", 64'(m1), 64'd0);
    chk("R10 count before deadline", count1, 64'd4);
    cyc();
    tick1 = 1'b0;
    chk("R9 system timer match", 64'(m1), 64'd1);
    chk("R9 irq bit placement", 64'(irq_bad), 64'd0);

    // R1 reset mid-run
    rst = 1'b1; cyc(); cyc(); rst = 1'b0; cyc();
    chk("R1 count after mid reset", count0, 64'h8000_0000_0000_0000);
    chk("R1 compare after mid reset", cmp0, 64'h8000_0000_0000_0000);
    chk("R1 system count after mid reset", count1, 64'h8000_0000_0000_0000);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule